// File: doc/BRIEF.md
# I2C Multi-Transaction Sequencer

This block runs an ordered list of I2C transactions as one locked bus operation. Each entry in a small descriptor store holds a 7-bit target address, a direction and a byte count of up to 255. A start request names how many entries to run. The sequencer then issues one command per transaction to a byte-level shifter: an address byte, a length and an end mode. Consecutive transactions are joined by repeated STARTs, and only the final transaction is marked to close the bus with an automatic STOP.

The shifter reports its progress on six event lines. The sequencer answers them from a fixed transition table. It moves transmit bytes out of an external byte buffer and writes received bytes back into it, using a single pointer that runs across the whole operation. When the operation ends it reports one result code. Any event the table does not allow in the current state is a fault, and a fault is handled like a bus error: a recovery pulse goes to the bus-clearing logic and the result reads as a bus error. A watchdog scaled to the size of the operation aborts a stalled transfer in the same way.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, cmd_valid_o and recover_o are low and ev_en_o is low.
- R2: A start request from idle with a count from 1 to DEPTH is accepted. One cycle later busy_o is high and cmd_valid_o pulses with cmd_abyte_o = {address, rd} (rd = 1 for read, 0 for write), cmd_len_o = the entry's byte count, and cmd_autoend_o = 1 only for the final entry. A count of 0, or a count above DEPTH, is rejected: rejected_o pulses and the block stays idle.
- R3: While a transaction has bytes left, a tx-empty event makes tx_valid_o pulse one cycle later, with the buffer byte at buf_raddr_o. An rx-not-empty event makes buf_we_o pulse one cycle later, with rx_data_i written at the pointer. The pointer starts at 0 and advances by one per byte across all transactions.
- R4: Simultaneous events are served one at a time in this order: rx-not-empty, tx-empty, NACK, transfer-complete, STOP. A bus error or a watchdog expiry outranks all of them.
- R5: A transfer-complete event on a transaction that is not the final one advances to the next entry. Two cycles later cmd_valid_o pulses with that entry's fields.
- R6: A STOP event on the final transaction ends the operation. One cycle later done_o pulses with result_o = 0 (OK) and busy_o drops.
- R7: A NACK event during an active transaction ends the operation two cycles later with result_o = 1 (NACK) and no recovery pulse.
- R8: A bus error during an operation pulses recover_o one cycle later. One cycle after that, done_o pulses with result_o = 2 (bus error).
- R9: These events are faults and end with a recovery pulse and result_o = 2: transfer-complete or STOP before the first data byte; a data event with no bytes left; transfer-complete on the final transaction; STOP on a transaction that is not the final one.
- R10: A start request while busy pulses rejected_o one cycle later. It issues no command and leaves the running operation and its byte pointer unchanged.
- R11: A bus error while idle pulses recover_o but produces no done_o pulse.
- R12: The watchdog budget is (transaction count + sum of byte counts) x 8 byte-times, each of BYTE_CYC cycles. With no events, done_o pulses with result_o = 2 exactly budget + 2 cycles after the start edge.
- R13: Event sources are enabled (ev_en_o high) only while a transaction is starting or moving data. Data, NACK, transfer-complete and STOP events while idle produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| start_cnt_i | input | CNT_W | Number of descriptors to run |
| busy_o | output | 1 | Operation in progress (lock held) |
| rejected_o | output | 1 | Start request refused |
| done_o | output | 1 | Operation finished, result valid |
| result_o | output | 2 | 0 OK, 1 NACK, 2 bus error |
| desc_we_i | input | 1 | Descriptor write strobe |
| desc_idx_i | input | IDX_W | Descriptor slot |
| desc_addr_i | input | 7 | Target address |
| desc_rd_i | input | 1 | 1 read, 0 write |
| desc_len_i | input | 8 | Data byte count |
| buf_raddr_o | output | BUF_AW | Byte buffer read address (current pointer) |
| buf_rdata_i | input | 8 | Byte buffer read data |
| buf_we_o | output | 1 | Byte buffer write strobe |
| buf_waddr_o | output | BUF_AW | Byte buffer write address |
| buf_wdata_o | output | 8 | Byte buffer write data |
| cmd_valid_o | output | 1 | Issue START plus address to shifter |
| cmd_abyte_o | output | 8 | Address byte {addr, rd} |
| cmd_len_o | output | 8 | Transaction byte count |
| cmd_autoend_o | output | 1 | Shifter sends STOP after this transaction |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| rx_data_i | input | 8 | Received byte from shifter |
| ev_en_o | output | 1 | Event sources enabled |
| ev_rxne_i | input | 1 | Receive byte available |
| ev_txe_i | input | 1 | Transmit holding empty |
| ev_nack_i | input | 1 | NACK seen |
| ev_tc_i | input | 1 | Transaction complete, no STOP |
| ev_stop_i | input | 1 | STOP seen |
| ev_berr_i | input | 1 | Bus error |
| recover_o | output | 1 | Trigger bus recovery |

## Verification
The embedded assertions check on every cycle that at most one of command, transmit, buffer write and done is active at a time. They also check that done only appears in the idle state, that a NACK closes without recovery, that a recovery pulse inside an operation is followed by a bus-error result, that a byte-count overrun lands in the fault state, that the idle state stays quiet, that a start while busy issues no command, and that the expired watchdog holds. Only the bench scenarios can show the rest. Those are the address-byte encoding, the byte order and global pointer across chained transactions, the service order of simultaneous events, the exact watchdog expiry cycle derived from the byte counts, and the complete set of fault transitions.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    S_FAULT    = 3'd0,
    S_BERR     = 3'd1,
    S_STOPPED  = 3'd2,
    S_STARTING = 3'd3,
    S_XFER     = 3'd4,
    S_NEXT     = 3'd5,
    S_NACK     = 3'd6
  } seq_state_e;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_RXNE = 3'd1,
    EV_TXE  = 3'd2,
    EV_NACK = 3'd3,
    EV_TC   = 3'd4,
    EV_STOP = 3'd5
  } seq_ev_e;

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_NACK = 2'd1;
  localparam logic [1:0] RES_BERR = 2'd2;

  localparam int NUM_EV = 5;

  typedef struct packed {
    logic [6:0] addr;
    logic       rd;
    logic [7:0] len;
  } desc_t;

endpackage

// File: rtl/i2c_seq_desc_mem.sv
module i2c_seq_desc_mem
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3,
  parameter int SUM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  desc_t            wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output desc_t            rdata_o,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [SUM_W-1:0] len_sum_o
);

  desc_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];

  // byte total over the entries an operation of cnt_i would run
  always_comb begin
    len_sum_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < cnt_i) len_sum_o = len_sum_o + SUM_W'(mem_q[i].len);
    end
  end

endmodule

// File: rtl/i2c_seq_evt_arb.sv
module i2c_seq_evt_arb
  import i2c_seq_pkg::*;
(
  input  logic              en_i,
  input  logic [NUM_EV-1:0] req_i,   // [0] highest priority
  output seq_ev_e           ev_o
);

  logic [NUM_EV-1:0] gnt;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_pri
    if (g == 0) begin : g_top
      assign gnt[g] = en_i & req_i[g];
    end else begin : g_rest
      assign gnt[g] = en_i & req_i[g] & ~(|req_i[g-1:0]);
    end
  end

  always_comb begin
    ev_o = EV_NONE;
    unique case (1'b1)
      gnt[0]:  ev_o = EV_RXNE;
      gnt[1]:  ev_o = EV_TXE;
      gnt[2]:  ev_o = EV_NACK;
      gnt[3]:  ev_o = EV_TC;
      gnt[4]:  ev_o = EV_STOP;
      default: ev_o = EV_NONE;
    endcase
  end

endmodule

// File: rtl/i2c_seq_wdog.sv
module i2c_seq_wdog #(
  parameter int CNT_W    = 3,
  parameter int SUM_W    = 12,
  parameter int BYTE_CYC = 4,
  parameter int WD_W     = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic             run_i,
  output logic             expired_o
);

  logic [WD_W-1:0] cnt_q;
  logic [WD_W-1:0] budget;

  assign budget = (WD_W'(cnt_i) + WD_W'(sum_i)) * WD_W'(BYTE_CYC * 8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= budget;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = run_i && (cnt_q == '0);

  AST_WD_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q == '0) |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3,
  parameter int BUF_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  seq_ev_e           ev_i,
  input  logic              berr_i,
  input  logic              tmo_i,
  input  desc_t             desc_i,
  input  logic [7:0]        buf_rdata_i,
  input  logic [7:0]        rx_data_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              start_go_o,
  output logic              busy_o,
  output logic              ev_en_o,
  output logic              rejected_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [BUF_AW-1:0] buf_raddr_o,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_waddr_o,
  output logic [7:0]        buf_wdata_o,
  output logic              cmd_valid_o,
  output logic [7:0]        cmd_abyte_o,
  output logic [7:0]        cmd_len_o,
  output logic              cmd_autoend_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              recover_o
);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, last_q, cnt_last, last_sel;
  logic [7:0]        rem_q;
  logic [BUF_AW-1:0] ptr_q;
  logic              err_q, nack_q, active_q;
  logic              cnt_ok, reject, act_tx, act_rx;
  logic              enter_start, enter_next, enter_err, finish, in_xfer;

  assign cnt_ok     = (cnt_i != '0) && (cnt_i <= CNT_W'(DEPTH));
  assign cnt_last   = IDX_W'(cnt_i - 1'b1);
  assign in_xfer    = (state_q == S_STARTING) || (state_q == S_XFER);
  assign busy_o     = (state_q != S_STOPPED);
  assign ev_en_o    = in_xfer;
  assign rd_idx_o   = (state_q == S_STOPPED) ? '0 : idx_q;
  assign last_sel   = (state_q == S_STOPPED) ? cnt_last : last_q;
  assign buf_raddr_o = ptr_q;

  assign start_go_o = (state_q == S_STOPPED) && start_i && cnt_ok && !berr_i;
  assign reject     = start_i && !start_go_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_STOPPED: begin
        if (berr_i)          state_d = S_BERR;
        else if (start_go_o) state_d = S_STARTING;
      end
      S_STARTING, S_XFER: begin
        if (berr_i || tmo_i) state_d = S_BERR;
        else begin
          unique case (ev_i)
            EV_RXNE, EV_TXE: state_d = (rem_q == '0) ? S_FAULT : S_XFER;
            EV_NACK:         state_d = S_NACK;
            EV_TC:   state_d = (state_q == S_STARTING || idx_q == last_q) ? S_FAULT : S_NEXT;
            EV_STOP: state_d = (state_q == S_STARTING || idx_q != last_q) ? S_FAULT : S_STOPPED;
            default: state_d = state_q;
          endcase
        end
      end
      S_NEXT:  state_d = (berr_i || tmo_i) ? S_BERR : S_STARTING;
      default: state_d = S_STOPPED;  // fault, bus error and NACK fall back on their own
    endcase
  end

  assign act_tx      = in_xfer && (state_d == S_XFER) && (ev_i == EV_TXE);
  assign act_rx      = in_xfer && (state_d == S_XFER) && (ev_i == EV_RXNE);
  assign enter_start = (state_d == S_STARTING) && (state_q != S_STARTING);
  assign enter_next  = (state_d == S_NEXT);
  assign enter_err   = (state_d == S_BERR) || (state_d == S_FAULT);
  assign finish      = active_q && (state_q != S_STOPPED) && (state_d == S_STOPPED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_STOPPED;
      idx_q         <= '0;
      last_q        <= '0;
      rem_q         <= '0;
      ptr_q         <= '0;
      err_q         <= 1'b0;
      nack_q        <= 1'b0;
      active_q      <= 1'b0;
      rejected_o    <= 1'b0;
      done_o        <= 1'b0;
      result_o      <= RES_OK;
      buf_we_o      <= 1'b0;
      buf_waddr_o   <= '0;
      buf_wdata_o   <= '0;
      cmd_valid_o   <= 1'b0;
      cmd_abyte_o   <= '0;
      cmd_len_o     <= '0;
      cmd_autoend_o <= 1'b0;
      tx_valid_o    <= 1'b0;
      tx_data_o     <= '0;
      recover_o     <= 1'b0;
    end else begin
      state_q     <= state_d;
      cmd_valid_o <= enter_start;
      tx_valid_o  <= act_tx;
      buf_we_o    <= act_rx;
      rejected_o  <= reject;
      recover_o   <= enter_err;
      done_o      <= finish;
      if (start_go_o) begin
        idx_q    <= '0;
        last_q   <= cnt_last;
        ptr_q    <= '0;
        err_q    <= 1'b0;
        nack_q   <= 1'b0;
        active_q <= 1'b1;
      end
      if (enter_start) begin
        cmd_abyte_o   <= {desc_i.addr, desc_i.rd};
        cmd_len_o     <= desc_i.len;
        cmd_autoend_o <= (rd_idx_o == last_sel);
        rem_q         <= desc_i.len;
      end
      if (act_tx) tx_data_o <= buf_rdata_i;
      if (act_rx) begin
        buf_waddr_o <= ptr_q;
        buf_wdata_o <= rx_data_i;
      end
      if (act_tx || act_rx) begin
        ptr_q <= ptr_q + 1'b1;
        rem_q <= rem_q - 1'b1;
      end
      if (enter_next) idx_q <= idx_q + 1'b1;
      if (state_d == S_NACK) nack_q <= 1'b1;
      if (enter_err) err_q <= 1'b1;
      if (finish) begin
        result_o <= err_q ? RES_BERR : (nack_q ? RES_NACK : RES_OK);
        active_q <= 1'b0;
      end
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, tx_valid_o, buf_we_o, done_o})); // R3
  AST_DONE_IN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == S_STOPPED)); // R6
  AST_NACK_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_NACK) |=> (done_o && result_o == RES_NACK && !recover_o)); // R7
  AST_ERR_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recover_o && active_q) |=> (done_o && result_o == RES_BERR)); // R8
  AST_OVERRUN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_XFER && rem_q == '0 && (ev_i == EV_TXE || ev_i == EV_RXNE) && !berr_i && !tmo_i)
      |=> (state_q == S_FAULT)); // R9
  AST_BUSY_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && state_q != S_NEXT) |=> !cmd_valid_o); // R10
  AST_BUSY_KEEP_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> $stable(last_q)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STOPPED && !start_i && !berr_i)
      |=> (state_q == S_STOPPED && !tx_valid_o && !buf_we_o && !done_o)); // R13

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int BUF_AW   = 10,
  parameter int BYTE_CYC = 4,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int SUM_W   = 8 + CNT_W + 1,
  localparam int WD_W    = SUM_W + 3 + $clog2(BYTE_CYC + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  output logic              busy_o,
  output logic              rejected_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  input  logic              desc_we_i,
  input  logic [IDX_W-1:0]  desc_idx_i,
  input  logic [6:0]        desc_addr_i,
  input  logic              desc_rd_i,
  input  logic [7:0]        desc_len_i,
  output logic [BUF_AW-1:0] buf_raddr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_waddr_o,
  output logic [7:0]        buf_wdata_o,
  output logic              cmd_valid_o,
  output logic [7:0]        cmd_abyte_o,
  output logic [7:0]        cmd_len_o,
  output logic              cmd_autoend_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic [7:0]        rx_data_i,
  output logic              ev_en_o,
  input  logic              ev_rxne_i,
  input  logic              ev_txe_i,
  input  logic              ev_nack_i,
  input  logic              ev_tc_i,
  input  logic              ev_stop_i,
  input  logic              ev_berr_i,
  output logic              recover_o
);

  desc_t            wr_desc, rd_desc;
  logic [IDX_W-1:0] rd_idx;
  logic [SUM_W-1:0] len_sum;
  seq_ev_e          ev;
  logic             tmo, start_go;

  assign wr_desc = '{addr: desc_addr_i, rd: desc_rd_i, len: desc_len_i};

  i2c_seq_desc_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_desc (
    .clk_i, .rst_ni,
    .we_i(desc_we_i), .widx_i(desc_idx_i), .wdata_i(wr_desc),
    .ridx_i(rd_idx), .rdata_o(rd_desc),
    .cnt_i(start_cnt_i), .len_sum_o(len_sum)
  );

  i2c_seq_evt_arb u_arb (
    .en_i (ev_en_o),
    .req_i({ev_stop_i, ev_tc_i, ev_nack_i, ev_txe_i, ev_rxne_i}),
    .ev_o (ev)
  );

  i2c_seq_wdog #(.CNT_W(CNT_W), .SUM_W(SUM_W), .BYTE_CYC(BYTE_CYC), .WD_W(WD_W)) u_wdog (
    .clk_i, .rst_ni,
    .load_i(start_go), .cnt_i(start_cnt_i), .sum_i(len_sum),
    .run_i(busy_o), .expired_o(tmo)
  );

  i2c_seq_fsm #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .BUF_AW(BUF_AW)) u_fsm (
    .clk_i, .rst_ni,
    .start_i, .cnt_i(start_cnt_i), .ev_i(ev), .berr_i(ev_berr_i), .tmo_i(tmo),
    .desc_i(rd_desc), .buf_rdata_i, .rx_data_i,
    .rd_idx_o(rd_idx), .start_go_o(start_go), .busy_o, .ev_en_o,
    .rejected_o, .done_o, .result_o,
    .buf_raddr_o, .buf_we_o, .buf_waddr_o, .buf_wdata_o,
    .cmd_valid_o, .cmd_abyte_o, .cmd_len_o, .cmd_autoend_o,
    .tx_valid_o, .tx_data_o, .recover_o
  );

endmodule

// File: tb/i2c_txn_seq_tb.sv
`timescale 1ns/1ps
module i2c_txn_seq_tb;

  localparam int BYTE_CYC = 4;
  localparam logic [5:0] E_RXNE = 6'b000001, E_TXE = 6'b000010, E_NACK = 6'b000100,
                         E_TC = 6'b001000, E_STOP = 6'b010000, E_BERR = 6'b100000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] start_cnt_i = '0;
  logic busy_o, rejected_o, done_o;
  logic [1:0] result_o;
  logic desc_we_i = 1'b0;
  logic [1:0] desc_idx_i = '0;
  logic [6:0] desc_addr_i = '0;
  logic desc_rd_i = 1'b0;
  logic [7:0] desc_len_i = '0;
  logic [9:0] buf_raddr_o, buf_waddr_o;
  logic [7:0] buf_rdata_i, buf_wdata_o;
  logic buf_we_o, cmd_valid_o, cmd_autoend_o, tx_valid_o, ev_en_o, recover_o;
  logic [7:0] cmd_abyte_o, cmd_len_o, tx_data_o;
  logic [7:0] rx_data_i = '0;
  logic [5:0] ev_vec = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] buf_pat(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction
  function automatic logic [7:0] rx_pat(input int a);
    return 8'((a * 13 + 5) & 8'hFF);
  endfunction

  assign buf_rdata_i = buf_pat(int'(buf_raddr_o));

  i2c_txn_seq #(.DEPTH(4), .BUF_AW(10), .BYTE_CYC(BYTE_CYC)) u_dut (
    .clk_i, .rst_ni, .start_i, .start_cnt_i, .busy_o, .rejected_o, .done_o, .result_o,
    .desc_we_i, .desc_idx_i, .desc_addr_i, .desc_rd_i, .desc_len_i,
    .buf_raddr_o, .buf_rdata_i, .buf_we_o, .buf_waddr_o, .buf_wdata_o,
    .cmd_valid_o, .cmd_abyte_o, .cmd_len_o, .cmd_autoend_o,
    .tx_valid_o, .tx_data_o, .rx_data_i, .ev_en_o,
    .ev_rxne_i(ev_vec[0]), .ev_txe_i(ev_vec[1]), .ev_nack_i(ev_vec[2]),
    .ev_tc_i(ev_vec[3]), .ev_stop_i(ev_vec[4]), .ev_berr_i(ev_vec[5]),
    .recover_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #2;
  endtask

  task automatic prog(input int idx, input int addr, input bit rd, input int len);
    desc_we_i = 1'b1; desc_idx_i = 2'(idx); desc_addr_i = 7'(addr);
    desc_rd_i = rd; desc_len_i = 8'(len);
    tick();
    desc_we_i = 1'b0;
  endtask

  task automatic start(input int cnt);
    start_i = 1'b1; start_cnt_i = 3'(cnt);
    tick();
    start_i = 1'b0;
  endtask

  task automatic ev(input logic [5:0] v);
    ev_vec = v;
    tick();
    ev_vec = '0;
  endtask

  task automatic chk_cmd(input string tag, input int addr, input bit rd, input int len, input bit last);
    chk({tag, " cmd_valid"}, cmd_valid_o, 1);
    chk({tag, " abyte"}, cmd_abyte_o, (addr << 1) | rd);
    chk({tag, " len"}, cmd_len_o, len);
    chk({tag, " autoend"}, cmd_autoend_o, last);
  endtask

  // moves one data byte and checks the resulting strobe
  task automatic byte_step(input string tag, input bit rd, input int gp);
    if (rd) begin
      rx_data_i = rx_pat(gp);
      ev(E_RXNE);
      chk({tag, " buf_we"}, buf_we_o, 1);
      chk({tag, " waddr"}, buf_waddr_o, gp);
      chk({tag, " wdata"}, buf_wdata_o, rx_pat(gp));
    end else begin
      ev(E_TXE);
      chk({tag, " tx_valid"}, tx_valid_o, 1);
      chk({tag, " tx_data"}, tx_data_o, buf_pat(gp));
    end
  endtask

  // waits for done, tracking recovery pulses along the way
  task automatic finish_op(input string tag, input int exp_res, input bit exp_rec);
    bit got = 0, rec = 0;
    int res = -1;
    for (int i = 0; i < 6 && !got; i++) begin
      rec |= recover_o;
      if (done_o) begin got = 1; res = result_o; end
      else tick();
    end
    chk({tag, " done"}, got, 1);
    chk({tag, " result"}, res, exp_res);
    chk({tag, " recover"}, rec, exp_rec);
    tick();
    chk({tag, " idle"}, busy_o, 0);
  endtask

  task automatic wd_case(input string tag, input int cnt, input int bytes);
    int budget = (cnt + bytes) * 8 * BYTE_CYC;
    int first = -1;
    start(cnt);
    for (int k = 1; k <= budget + 4; k++) begin
      tick();
      if (done_o && first < 0) begin
        first = k;
        chk({tag, " result"}, result_o, 2);
      end
    end
    chk({tag, " expiry cycle"}, first, budget + 2);
  endtask

  initial begin
    int gp;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 cmd", cmd_valid_o, 0);
    chk("R1 recover", recover_o, 0);
    chk("R1 ev_en", ev_en_o, 0);

    // R13 events while idle are masked
    ev(E_RXNE | E_TXE | E_NACK | E_TC | E_STOP);
    chk("R13 tx", tx_valid_o, 0);
    chk("R13 we", buf_we_o, 0);
    chk("R13 done", done_o, 0);
    chk("R13 busy", busy_o, 0);

    // R2 R3 R6 sweep of single transactions
    for (int len = 1; len <= 6; len++) begin
      for (int rd = 0; rd < 2; rd++) begin
        int addr = (len * 19 + rd * 45) & 7'h7F;
        prog(0, addr, rd[0], len);
        start(1);
        chk_cmd("R2 single", addr, rd[0], len, 1);
        chk("R2 busy", busy_o, 1);
        chk("R13 ev_en active", ev_en_o, 1);
        for (int b = 0; b < len; b++) byte_step("R3 single", rd[0], b);
        ev(E_STOP);
        chk("R6 done", done_o, 1);
        chk("R6 result", result_o, 0);
        tick();
        chk("R6 busy", busy_o, 0);
      end
    end

    // R5 chained transactions with a global pointer
    for (int n = 2; n <= 4; n++) begin
      for (int i = 0; i < n; i++) prog(i, 16 + i + n, i[0], i + 1);
      start(n);
      gp = 0;
      for (int i = 0; i < n; i++) begin
        if (i > 0) begin
          ev(E_TC);
          chk("R5 no early cmd", cmd_valid_o, 0);
          tick();
        end
        chk_cmd("R5 chain", 16 + i + n, i[0], i + 1, i == n - 1);
        for (int b = 0; b <= i; b++) begin
          byte_step("R5 chain", i[0], gp);
          gp++;
        end
      end
      ev(E_STOP);
      finish_op("R5 chain end", 0, 0);
    end

    // R2 invalid counts
    start(0);
    chk("R2 zero rejected", rejected_o, 1);
    chk("R2 zero idle", busy_o, 0);
    start(5);
    chk("R2 over rejected", rejected_o, 1);
    chk("R2 over no cmd", cmd_valid_o, 0);

    // R7 NACK on address
    prog(0, 7'h33, 0, 2);
    start(1);
    ev(E_NACK);
    finish_op("R7 nack", 1, 0);

    // R8 bus error mid transfer
    start(1);
    byte_step("R8 pre", 0, 0);
    ev(E_BERR);
    chk("R8 recover", recover_o, 1);
    finish_op("R8 berr", 2, 1);

    // R9 fault transitions
    start(1); ev(E_TC);   finish_op("R9 tc at start", 2, 1);
    start(1); ev(E_STOP); finish_op("R9 stop at start", 2, 1);
    start(1);
    byte_step("R9 ovr", 0, 0); byte_step("R9 ovr", 0, 1);
    ev(E_TXE);
    chk("R9 overrun no tx", tx_valid_o, 0);
    finish_op("R9 overrun", 2, 1);
    start(1); byte_step("R9 tclast", 0, 0); ev(E_TC); finish_op("R9 tc on last", 2, 1);
    prog(1, 7'h44, 1, 1);
    start(2); byte_step("R9 stopmid", 0, 0); ev(E_STOP); finish_op("R9 stop not last", 2, 1);

    // R4 priority
    prog(0, 7'h21, 1, 3);
    start(1);
    rx_data_i = rx_pat(0);
    ev(E_RXNE | E_TXE);
    chk("R4 rxne over txe we", buf_we_o, 1);
    chk("R4 rxne over txe tx", tx_valid_o, 0);
    ev(E_TXE | E_NACK | E_TC | E_STOP);
    chk("R4 txe over rest", tx_valid_o, 1);
    chk("R4 txe ptr", tx_data_o, buf_pat(1));
    ev(E_NACK | E_TC | E_STOP);
    finish_op("R4 nack over tc", 1, 0);
    prog(0, 7'h21, 0, 1);
    start(1); byte_step("R4 pre", 0, 0);
    ev(E_TC | E_STOP);
    finish_op("R4 tc over stop", 2, 1);
    start(1); byte_step("R4 pre2", 0, 0);
    ev(E_BERR | E_STOP);
    finish_op("R4 berr over stop", 2, 1);

    // R10 start while busy
    prog(0, 7'h5A, 0, 2);
    start(1);
    byte_step("R10 pre", 0, 0);
    start(3);
    chk("R10 rejected", rejected_o, 1);
    chk("R10 no cmd", cmd_valid_o, 0);
    byte_step("R10 pointer kept", 0, 1);
    ev(E_STOP);
    finish_op("R10 completes", 0, 0);

    // R11 bus error while idle
    ev(E_BERR);
    chk("R11 recover", recover_o, 1);
    begin
      bit seen = 0;
      for (int i = 0; i < 4; i++) begin
        seen |= done_o;
        tick();
      end
      chk("R11 no done", seen, 0);
      chk("R11 idle", busy_o, 0);
    end

    // R12 watchdog
    prog(0, 7'h11, 0, 2);
    wd_case("R12 one", 1, 2);
    prog(1, 7'h12, 1, 3);
    wd_case("R12 two", 2, 5);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule